// File: doc/BRIEF.md
# Flash Write-Command Sequence Decoder

This block sits behind the bus capture logic of a NOR-style flash controller. Every write to the flash reaches it as a one-cycle strobe with the 19-bit word address and 16-bit data word already latched. The block follows the multi-write unlock protocol. When a sequence completes, it emits one decoded request: program, chip erase, sector erase with a bitmask of sectors, identify entry, return to read, erase suspend, erase resume, or fast-mode entry or exit. The array, the program and erase timing, and protection all live downstream.

A sequence starts with two unlock writes: 0xAA to the word address whose low eleven bits are 0x555, then 0x55 to low bits 0x2AA. The third write selects the command. Sector erase gathers sectors during a time window, and the erase request leaves when that window lapses. A shortened program sequence is available once fast mode has been entered. While the downstream engine reports busy, only the suspend command gets through.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, req_valid_o and fast_mode_o are 0 and the decoder is at the start of a sequence (read mode).
- R2: The writes AA@555, 55@2AA, A0@555 followed by any write produce a program request. This is kind code 1, carrying the full address and data of that fourth write.
- R3: Unlock and command writes compare only address bits 10:0. Bits 18:11 may hold any value.
- R4: A write that does not fit its position in a normal sequence returns the decoder to read mode and emits nothing. A later command write then starts nothing.
- R5: Outside the program-data step and outside fast mode, a single write of 0xF0 to any address emits a read/reset request (kind 5) and returns to read mode. This also applies part way through a sequence.
- R6: The unlock pair followed by 0x90 at 555 emits an identify-entry request (kind 4).
- R7: The unlock pair, 0x80@555, the unlock pair again, then 0x10@555 emits a chip-erase request (kind 2).
- R8: If that last write is instead 0x30 to any address, sector address bits 18:12 set one bit of a 128-bit mask and open a window of WIN_CYCLES cycles. Each further 0x30 write adds a bit and restarts the window. When WIN_CYCLES cycles pass with no write, a sector-erase request (kind 3) carries the mask. Any other write during the window discards the set; 0xF0 still yields kind 5.
- R9: While busy_i is high, 0xB0 written to any address emits suspend (kind 6). In read mode with busy_i low, 0x30 emits resume (kind 7). Both carry bank = address bits 18:16.
- R10: While busy_i is high, every write other than 0xB0 is ignored: it emits nothing and keeps the sequence position.
- R11: The unlock pair followed by 0x20@555 emits fast-entry (kind 8) and raises fast_mode_o. In fast mode, 0xA0 then any write emits a program request (kind 1). 0x90 then 0xF0 emits fast-exit (kind 9) and drops fast_mode_o. Any other write in fast mode emits nothing and leaves fast mode on.
- R12: Requests are registered: req_valid_o pulses for exactly the one cycle after the clock edge that sampled the completing write, or that ended the erase window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Embedded program/erase operation in progress |
| wr_stb_i | input | 1 | One-cycle strobe of a captured write |
| wr_addr_i | input | 19 | Captured word address |
| wr_data_i | input | 16 | Captured data word, command in bits 7:0 |
| req_valid_o | output | 1 | Decoded request pulse |
| req_kind_o | output | 4 | Request code (see requirements) |
| req_addr_o | output | 19 | Address of the completing write |
| req_data_o | output | 16 | Data of the completing write |
| req_sector_mask_o | output | 128 | Sector set of a sector-erase request |
| req_bank_o | output | 3 | Bank of a suspend or resume request |
| fast_mode_o | output | 1 | Fast mode active |

## Verification
A wrong sequence position shows up at the ports only when the next command completes. It appears either as a request that should not leave, or as one that goes missing, so checks include probes written right after aborted or held sequences. A wrong sector window appears as a sector-erase pulse a cycle early or late, or with a missing mask bit. A per-cycle comparison catches these in the cycle they occur. A fast-mode fault shows at once on fast_mode_o.

// File: rtl/fcd_pkg.sv
// Shared codes for the flash write-command decoder.
// Assumes the command byte sits in data bits 7:0 and unlock addresses use 11 bits.
package fcd_pkg;
    localparam int CMP_W = 11;
    localparam logic [CMP_W-1:0] ADR_UNL_A = 11'h555;
    localparam logic [CMP_W-1:0] ADR_UNL_B = 11'h2AA;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_FAST    = 8'h20;

    typedef enum logic [3:0] {
        REQ_NONE         = 4'd0,
        REQ_PROGRAM      = 4'd1,
        REQ_CHIP_ERASE   = 4'd2,
        REQ_SECTOR_ERASE = 4'd3,
        REQ_IDENTIFY     = 4'd4,
        REQ_READ_RESET   = 4'd5,
        REQ_SUSPEND      = 4'd6,
        REQ_RESUME       = 4'd7,
        REQ_FAST_ENTER   = 4'd8,
        REQ_FAST_EXIT    = 4'd9
    } req_kind_e;

    typedef enum logic [3:0] {
        S_READ, S_UNL1, S_UNL2, S_PROG,
        S_ERA0, S_ERA1, S_ERA2, S_WIN,
        S_FAST, S_FAST_PROG, S_FAST_EXIT
    } seq_state_e;
endpackage

// File: rtl/fcd_erase_set.sv
// Sector erase set accumulator with a restartable collection window.
// start_i replaces the set, add_i extends it; both restart the window.
// expired_o is high once WIN_CYCLES cycles have passed without start/add.
// Assumes the caller never raises clear_i together with start_i or add_i.
module fcd_erase_set #(
    parameter int SECT_W     = 7,
    parameter int WIN_CYCLES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    add_i,
    input  logic                    clear_i,
    input  logic [SECT_W-1:0]       sect_i,
    output logic [(1<<SECT_W)-1:0]  mask_o,
    output logic                    expired_o
);
    localparam int NSECT = 1 << SECT_W;
    localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WIN_CYCLES - 1);

    logic [NSECT-1:0] hit;
    logic             armed;
    logic [CNT_W-1:0] cnt;

    // One decoder bit per sector slot.
    generate
        for (genvar g = 0; g < NSECT; g++) begin : g_dec
            assign hit[g] = (sect_i == SECT_W'(g));
        end
    endgenerate

    // Set register and window countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
            armed  <= 1'b0;
            cnt    <= '0;
        end else if (start_i) begin
            mask_o <= hit;
            armed  <= 1'b1;
            cnt    <= RELOAD;
        end else if (add_i) begin
            mask_o <= mask_o | hit;
            armed  <= 1'b1;
            cnt    <= RELOAD;
        end else if (clear_i) begin
            mask_o <= '0;
            armed  <= 1'b0;
            cnt    <= '0;
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Window lapse flag.
    assign expired_o = armed && (cnt == '0);

    // R8
    set_records_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || add_i) |=> (!expired_o || WIN_CYCLES == 1) && mask_o[$past(sect_i)]);

    // R8
    expire_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !start_i && !add_i && !clear_i) |=> expired_o);
endmodule

// File: rtl/fcd_seq.sv
// Write-sequence state machine of the flash command decoder.
// Consumes one captured write per strobe, tracks the unlock position and
// fast mode, drives the erase set, and registers one request per completion.
// Assumes wr_stb_i is a single-cycle pulse per bus write.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 12,
    parameter int BANK_LSB = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              busy_i,
    input  logic                              wr_stb_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    input  logic                              win_expired_i,
    input  logic [(1<<(ADDR_W-SECT_LSB))-1:0] set_mask_i,
    output logic                              win_start_o,
    output logic                              win_add_o,
    output logic                              win_clear_o,
    output logic [ADDR_W-SECT_LSB-1:0]        sect_idx_o,
    output logic                              req_valid_o,
    output logic [3:0]                        req_kind_o,
    output logic [ADDR_W-1:0]                 req_addr_o,
    output logic [DATA_W-1:0]                 req_data_o,
    output logic [(1<<(ADDR_W-SECT_LSB))-1:0] req_mask_o,
    output logic [ADDR_W-BANK_LSB-1:0]        req_bank_o,
    output logic                              fast_mode_o
);
    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int BANK_W = ADDR_W - BANK_LSB;

    seq_state_e st, nxt;
    req_kind_e  kind_n, kind_q;
    logic [7:0] cmd;
    logic       at_a, at_b, take;

    assign cmd        = wr_data_i[7:0];
    assign at_a       = (wr_addr_i[CMP_W-1:0] == ADR_UNL_A);
    assign at_b       = (wr_addr_i[CMP_W-1:0] == ADR_UNL_B);
    assign take       = wr_stb_i && !busy_i;
    assign sect_idx_o = wr_addr_i[ADDR_W-1:SECT_LSB];

    // Next position, request and erase-set control for the current cycle.
    always_comb begin
        nxt         = st;
        kind_n      = REQ_NONE;
        win_start_o = 1'b0;
        win_add_o   = 1'b0;
        win_clear_o = 1'b0;
        if (wr_stb_i && busy_i) begin
            if (cmd == CMD_SUSPEND) kind_n = REQ_SUSPEND;
        end else if (take) begin
            case (st)
                S_FAST:      if (cmd == CMD_PROG) nxt = S_FAST_PROG;
                             else if (cmd == CMD_IDENT) nxt = S_FAST_EXIT;
                S_FAST_PROG: begin kind_n = REQ_PROGRAM; nxt = S_FAST; end
                S_FAST_EXIT: if (cmd == CMD_RESET) begin
                                 kind_n = REQ_FAST_EXIT; nxt = S_READ;
                             end else nxt = S_FAST;
                S_PROG:      begin kind_n = REQ_PROGRAM; nxt = S_READ; end
                default: begin
                    nxt = S_READ;
                    if (cmd == CMD_RESET) begin
                        kind_n      = REQ_READ_RESET;
                        win_clear_o = (st == S_WIN);
                    end else begin
                        case (st)
                            S_READ: if (at_a && cmd == CMD_KEY_A) nxt = S_UNL1;
                                    else if (cmd == CMD_SECTOR) kind_n = REQ_RESUME;
                            S_UNL1: if (at_b && cmd == CMD_KEY_B) nxt = S_UNL2;
                            S_UNL2: if (at_a) begin
                                        case (cmd)
                                            CMD_PROG:  nxt = S_PROG;
                                            CMD_ERASE: nxt = S_ERA0;
                                            CMD_IDENT: kind_n = REQ_IDENTIFY;
                                            CMD_FAST:  begin kind_n = REQ_FAST_ENTER; nxt = S_FAST; end
                                            default:   nxt = S_READ;
                                        endcase
                                    end
                            S_ERA0: if (at_a && cmd == CMD_KEY_A) nxt = S_ERA1;
                            S_ERA1: if (at_b && cmd == CMD_KEY_B) nxt = S_ERA2;
                            S_ERA2: if (at_a && cmd == CMD_CHIP) kind_n = REQ_CHIP_ERASE;
                                    else if (cmd == CMD_SECTOR) begin
                                        win_start_o = 1'b1; nxt = S_WIN;
                                    end
                            S_WIN:  if (cmd == CMD_SECTOR) begin
                                        win_add_o = 1'b1; nxt = S_WIN;
                                    end else win_clear_o = 1'b1;
                            default: nxt = S_READ;
                        endcase
                    end
                end
            endcase
        end
        // Window lapse issues the erase when no write claimed this cycle.
        if (st == S_WIN && win_expired_i && !take && kind_n == REQ_NONE) begin
            kind_n      = REQ_SECTOR_ERASE;
            win_clear_o = 1'b1;
            nxt         = S_READ;
        end
    end

    // Sequence position register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_READ;
        else        st <= nxt;
    end

    // Registered request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid_o <= 1'b0;
            kind_q      <= REQ_NONE;
            req_addr_o  <= '0;
            req_data_o  <= '0;
            req_mask_o  <= '0;
            req_bank_o  <= '0;
        end else begin
            req_valid_o <= (kind_n != REQ_NONE);
            if (kind_n != REQ_NONE) begin
                kind_q     <= kind_n;
                req_addr_o <= wr_addr_i;
                req_data_o <= wr_data_i;
                req_mask_o <= set_mask_i;
                req_bank_o <= wr_addr_i[ADDR_W-1:BANK_LSB];
            end
        end
    end

    assign req_kind_o  = kind_q;
    assign fast_mode_o = (st == S_FAST) || (st == S_FAST_PROG) || (st == S_FAST_EXIT);

    // R8
    sector_mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && kind_q == REQ_SECTOR_ERASE) |-> (req_mask_o != '0));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_stb_i && cmd != CMD_SUSPEND) |=> (!req_valid_o || kind_q == REQ_SECTOR_ERASE));

    // R11
    fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_mode_o) |-> (req_valid_o && kind_q == REQ_FAST_ENTER));

    // R11
    fast_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_mode_o) |-> (req_valid_o && kind_q == REQ_FAST_EXIT));

    // R12
    req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && kind_q != REQ_SECTOR_ERASE) |-> $past(wr_stb_i));

    // R9
    bank_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && (kind_q == REQ_SUSPEND || kind_q == REQ_RESUME))
            |-> (req_bank_o == req_addr_o[ADDR_W-1:BANK_LSB]) && (BANK_W > 0));

    // The sector index is only meaningful to the erase set.
    initial assert (SECT_W > 0 && SECT_W <= 8);
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash write-command decoder: sequence machine plus erase set.
// Assumes writes arrive already captured (address and data latched with the strobe).
module flash_cmd_decoder #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 16,
    parameter int SECT_LSB   = 12,
    parameter int BANK_LSB   = 16,
    parameter int WIN_CYCLES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              busy_i,
    input  logic                              wr_stb_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    output logic                              req_valid_o,
    output logic [3:0]                        req_kind_o,
    output logic [ADDR_W-1:0]                 req_addr_o,
    output logic [DATA_W-1:0]                 req_data_o,
    output logic [(1<<(ADDR_W-SECT_LSB))-1:0] req_sector_mask_o,
    output logic [ADDR_W-BANK_LSB-1:0]        req_bank_o,
    output logic                              fast_mode_o
);
    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int NSECT  = 1 << SECT_W;

    logic              win_start, win_add, win_clear, win_expired;
    logic [SECT_W-1:0] sect_idx;
    logic [NSECT-1:0]  set_mask;

    fcd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .BANK_LSB(BANK_LSB)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .wr_stb_i(wr_stb_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .win_expired_i(win_expired), .set_mask_i(set_mask),
        .win_start_o(win_start), .win_add_o(win_add), .win_clear_o(win_clear),
        .sect_idx_o(sect_idx),
        .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
        .req_addr_o(req_addr_o), .req_data_o(req_data_o),
        .req_mask_o(req_sector_mask_o), .req_bank_o(req_bank_o),
        .fast_mode_o(fast_mode_o)
    );

    fcd_erase_set #(
        .SECT_W(SECT_W), .WIN_CYCLES(WIN_CYCLES)
    ) u_set (
        .clk(clk), .rst_n(rst_n), .start_i(win_start), .add_i(win_add),
        .clear_i(win_clear), .sect_i(sect_idx),
        .mask_o(set_mask), .expired_o(win_expired)
    );
endmodule

// File: tb/flash_cmd_decoder_bench.sv
// Bench: behavioural reference model compared against the decoder every clock.
module flash_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 8;
    localparam int NSECT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic        stb = 1'b0;
    logic [18:0] waddr = '0;
    logic [15:0] wdata = '0;
    logic             req_valid, fast_mode;
    logic [3:0]       req_kind;
    logic [18:0]      req_addr;
    logic [15:0]      req_data;
    logic [NSECT-1:0] req_mask;
    logic [2:0]       req_bank;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit seen_reset = 0;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_stb_i(stb),
        .wr_addr_i(waddr), .wr_data_i(wdata),
        .req_valid_o(req_valid), .req_kind_o(req_kind), .req_addr_o(req_addr),
        .req_data_o(req_data), .req_sector_mask_o(req_mask), .req_bank_o(req_bank),
        .fast_mode_o(fast_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what,
                       input logic [NSECT-1:0] act, input logic [NSECT-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    // Reference model state: step counts writes into a sequence.
    int pos = 0;            // 0 read,1-2 unlock,3 program data,4-6 erase,7 window,10-12 fast
    int wleft = 0;
    logic [NSECT-1:0] m_mask = '0;
    bit e_v; int e_k; logic [18:0] e_addr; logic [15:0] e_data;
    logic [2:0] e_bank; logic [NSECT-1:0] e_mask;

    task automatic put(input int k);
        e_v = 1; e_k = k; e_addr = waddr; e_data = wdata;
        e_bank = waddr[18:16]; e_mask = m_mask;
    endtask

    always @(posedge clk) begin
        logic [7:0] c;
        bit lo_a, lo_b, acc;
        c = wdata[7:0];
        lo_a = (waddr[10:0] == 11'h555);
        lo_b = (waddr[10:0] == 11'h2AA);
        acc = stb && !busy;
        e_v = 0;
        if (!rst_n) begin
            pos = 0; wleft = 0; m_mask = '0; seen_reset = 1;
        end else begin
            if (stb && busy) begin
                if (c == 8'hB0) put(6);
            end else if (acc) begin
                if (pos >= 10) begin
                    if (pos == 11) begin put(1); pos = 10; end
                    else if (pos == 12) begin
                        if (c == 8'hF0) begin put(9); pos = 0; end else pos = 10;
                    end else if (c == 8'hA0) pos = 11;
                    else if (c == 8'h90) pos = 12;
                end else if (pos == 3) begin
                    put(1); pos = 0;
                end else if (c == 8'hF0) begin
                    put(5); pos = 0; m_mask = '0;
                end else begin
                    case (pos)
                        0: if (lo_a && c == 8'hAA) pos = 1; else if (c == 8'h30) put(7);
                        1: pos = (lo_b && c == 8'h55) ? 2 : 0;
                        2: begin
                            pos = 0;
                            if (lo_a) begin
                                if (c == 8'hA0) pos = 3;
                                else if (c == 8'h80) pos = 4;
                                else if (c == 8'h90) put(4);
                                else if (c == 8'h20) begin put(8); pos = 10; end
                            end
                        end
                        4: pos = (lo_a && c == 8'hAA) ? 5 : 0;
                        5: pos = (lo_b && c == 8'h55) ? 6 : 0;
                        6: begin
                            pos = 0;
                            if (lo_a && c == 8'h10) put(2);
                            else if (c == 8'h30) begin
                                m_mask = NSECT'(1) << waddr[18:12]; wleft = WIN; pos = 7;
                            end
                        end
                        7: if (c == 8'h30) begin
                               m_mask = m_mask | (NSECT'(1) << waddr[18:12]); wleft = WIN;
                           end else begin pos = 0; m_mask = '0; end
                        default: pos = 0;
                    endcase
                end
            end
            if (pos == 7 && !acc) begin
                if (wleft > 1) wleft--;
                else if (!e_v) begin put(3); pos = 0; m_mask = '0; end
            end
        end
        #(CLK_PERIOD/4);
        if (seen_reset) begin
            // R12: request pulse lands in exactly the expected cycle
            chk(req_valid == e_v, "req_valid", NSECT'(req_valid), NSECT'(e_v));
            chk(fast_mode == (pos >= 10), "fast_mode", NSECT'(fast_mode), NSECT'(pos >= 10));
            if (e_v && req_valid) begin
                chk(req_kind == 4'(e_k), "kind", NSECT'(req_kind), NSECT'(e_k));
                if (e_k == 1) begin
                    chk(req_addr == e_addr, "addr", NSECT'(req_addr), NSECT'(e_addr));
                    chk(req_data == e_data, "data", NSECT'(req_data), NSECT'(e_data));
                end
                if (e_k == 3) chk(req_mask == e_mask, "mask", req_mask, e_mask);
                if (e_k == 6 || e_k == 7)
                    chk(req_bank == e_bank, "bank", NSECT'(req_bank), NSECT'(e_bank));
            end
        end
    end

    task automatic wr(input logic [18:0] a, input logic [15:0] d);
        @(negedge clk); stb = 1'b1; waddr = a; wdata = d;
        @(negedge clk); stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic unlock();
        wr(19'h00555, 16'h00AA); wr(19'h002AA, 16'h0055);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        phase = "R1";
        chk(req_valid == 1'b0 && fast_mode == 1'b0, "reset outputs",
            NSECT'({req_valid, fast_mode}), '0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        phase = "R2"; unlock(); wr(19'h00555, 16'h00A0); wr(19'h51234, 16'hBEEF); idle(2);
        phase = "R3"; wr(19'h7F555, 16'h00AA); wr(19'h3A2AA, 16'h0055);
        wr(19'h12555, 16'h00A0); wr(19'h7FFFF, 16'h00F0); idle(2);
        phase = "R4"; wr(19'h00455, 16'h00AA); wr(19'h002AA, 16'h0055);
        wr(19'h00555, 16'h00A0); wr(19'h01000, 16'h1234); idle(1);
        wr(19'h00555, 16'h00AA); wr(19'h002AB, 16'h0055);
        wr(19'h00555, 16'h00A0); wr(19'h02000, 16'h5678); idle(2);
        phase = "R5"; wr(19'h4ABCD, 16'h00F0); unlock(); wr(19'h00123, 16'h00F0); idle(2);
        phase = "R6"; unlock(); wr(19'h00555, 16'h0090); idle(2);
        phase = "R7"; unlock(); wr(19'h00555, 16'h0080); unlock(); wr(19'h40555, 16'h0010); idle(2);
        phase = "R8"; unlock(); wr(19'h00555, 16'h0080); unlock();
        wr(19'h34000, 16'h0030); idle(3); wr(19'h7F000, 16'h0030);
        wr(19'h00000, 16'h0030); idle(WIN + 3);
        unlock(); wr(19'h00555, 16'h0080); unlock();
        wr(19'h05000, 16'h0030); wr(19'h06000, 16'h0012); idle(WIN + 2);
        unlock(); wr(19'h00555, 16'h0080); unlock();
        wr(19'h05000, 16'h0030); wr(19'h06000, 16'h00F0); idle(WIN + 2);
        phase = "R9"; busy = 1'b1; wr(19'h50000, 16'h00B0); busy = 1'b0;
        wr(19'h60000, 16'h0030); idle(2);
        phase = "R10"; wr(19'h00555, 16'h00AA); busy = 1'b1;
        wr(19'h002AA, 16'h0055); wr(19'h11111, 16'h00F0); busy = 1'b0;
        wr(19'h002AA, 16'h0055); wr(19'h00555, 16'h00A0); wr(19'h2ABCD, 16'h0F0F); idle(2);
        phase = "R11"; unlock(); wr(19'h00555, 16'h0020); wr(19'h00000, 16'h00A0);
        wr(19'h3C0DE, 16'hA5A5); wr(19'h00000, 16'h00F0); wr(19'h00000, 16'h0090);
        wr(19'h00000, 16'h0012); wr(19'h00000, 16'h00A0); wr(19'h01111, 16'h0090);
        wr(19'h00000, 16'h0090); wr(19'h00000, 16'h00F0); idle(3);
        phase = "R12"; unlock(); wr(19'h00555, 16'h0090); idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule